// File: doc/BRIEF.md
# Transceiver Channel Reset Sequencer

This block is a synchronous state machine for one serial transceiver channel on a PCIe-style link. It takes the channel from power-up to normal operation. It first holds the transmit PLL powered down. It then waits for the transmit PLL to lock and releases transmit digital reset. Next it releases the receive analog front end and waits for the receive PLL to lock. After a settling period it moves the clock-data-recovery circuit from tracking the reference clock to tracking incoming data. Finally it releases receive digital reset, which ends the sequence.

Every wait is a whole number of cycles of a free-running clock. Each is rounded up from a time in nanoseconds and the clock frequency parameter, so no minimum interval comes out short. The three lock inputs are asynchronous and pass through a two-stage synchronizer before the state machine sees them. A synchronous reset or a one-cycle restart request sends the sequence back to power-down at any time. Loss of a lock input sends it back to the state that depends on that lock. The sequence is the same whether or not a rate-compensation FIFO follows the receiver. Receive data should be treated as invalid while `busy` is high.

Top module: `xcvr_rst_seq`

## Requirements
- R1: While `rst` is high, `pll_pwrdn`, `tx_dig_rst`, `rx_ana_rst`, `rx_dig_rst`, `cdr_ref_sel` and `busy` are 1, and `cdr_data_sel` and `done` are 0.
- R2: After `rst` falls or a restart, `pll_pwrdn` stays high for exactly ceil(PWRDN_NS*CLK_MHZ/1000) cycles, whatever the lock inputs are doing.
- R3: `tx_dig_rst` falls TXREL_CYC cycles after the synchronized transmit lock is seen. Counted from the clock cycle in which `tx_lock_a` rises, this is 3+TXREL_CYC cycles.
- R4: `rx_ana_rst` stays high for exactly ceil(RXANA_NS*CLK_MHZ/1000) cycles after `tx_dig_rst` falls.
- R5: `cdr_ref_sel` falls and `cdr_data_sel` rises in the same cycle. This happens ceil(SETTLE_NS*CLK_MHZ/1000) cycles after the synchronized receive PLL lock is seen, which is that count plus 3 cycles from the rise of `rx_lock_a`.
- R6: `rx_dig_rst` stays high for at least ceil(RXDIG_NS*CLK_MHZ/1000) cycles after `cdr_data_sel` rises. It is exactly that count when frequency lock is already present.
- R7: In the operating state `done` is 1, and `busy`, `tx_dig_rst`, `rx_ana_rst` and `rx_dig_rst` are 0. `done` is 1 in no other state.
- R8: `rx_dig_rst` is not released while the synchronized `rx_freq_lock_a` is low. Once it rises, `rx_dig_rst` falls 3 cycles after the change in the input.
- R9: A drop of the receive PLL lock after it has been seen returns the sequence to the receive analog hold. `rx_ana_rst`, `rx_dig_rst` and `cdr_ref_sel` go to 1, and `tx_dig_rst` stays 0.
- R10: A drop of transmit lock after transmit lock has been seen returns the sequence to power-down.
- R11: `restart_req` high at a clock edge puts the sequence in power-down after that edge.
- R12: A change on any lock input reaches the state machine through two flip-flops. Its effect shows on the outputs after the third clock edge that follows the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock for all timing |
| rst | input | 1 | Synchronous active-high reset |
| restart_req | input | 1 | Synchronous request to restart the sequence |
| tx_lock_a | input | 1 | Transmit PLL lock, asynchronous |
| rx_lock_a | input | 1 | Receive PLL lock, asynchronous |
| rx_freq_lock_a | input | 1 | Receiver frequency lock, asynchronous |
| pll_pwrdn | output | 1 | Transmit PLL power-down |
| tx_dig_rst | output | 1 | Transmit digital reset |
| rx_ana_rst | output | 1 | Receive analog reset |
| rx_dig_rst | output | 1 | Receive digital reset |
| cdr_ref_sel | output | 1 | Recovery circuit tracks the reference clock |
| cdr_data_sel | output | 1 | Recovery circuit tracks incoming data |
| busy | output | 1 | Sequence not yet complete; receive data invalid |
| done | output | 1 | Sequence complete, channel operating |

## Verification
The assertions check several properties on every cycle. The power-down and receive-digital-reset hold times are measured by run-length counters. The switch from the reference clock to data must happen in a single cycle. Receive digital reset is never released without data tracking and frequency lock. The operating state has clean outputs, and restart or transmit-lock loss always forces power-down. The exact interval lengths, the latency through the synchronizer, the holding of reset while frequency lock is missing, and recovery back to the operating state after a lock is lost can only be shown by the bench's scenarios.

// File: rtl/xrs_pkg.sv
package xrs_pkg;

    typedef enum logic [2:0] {
        ST_PWRDN,
        ST_WAIT_TX,
        ST_TX_HOLD,
        ST_RXANA_HOLD,
        ST_WAIT_RX,
        ST_SETTLE,
        ST_LTD,
        ST_RUN
    } seq_state_e;

    typedef struct packed {
        logic pll_pwrdn;
        logic tx_dig_rst;
        logic rx_ana_rst;
        logic rx_dig_rst;
        logic ref_sel;
        logic data_sel;
    } ctl_t;

    // Nanoseconds to clock cycles, rounded up, never below one cycle.
    function automatic int ns_to_cyc(input int ns, input int mhz);
        int c;
        c = (ns * mhz + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic ctl_t decode(input seq_state_e st);
        ctl_t c;
        c = '{pll_pwrdn: 1'b0, tx_dig_rst: 1'b1, rx_ana_rst: 1'b1,
              rx_dig_rst: 1'b1, ref_sel: 1'b1, data_sel: 1'b0};
        case (st)
            ST_PWRDN:      c.pll_pwrdn = 1'b1;
            ST_WAIT_TX,
            ST_TX_HOLD:    ;
            ST_RXANA_HOLD: c.tx_dig_rst = 1'b0;
            ST_WAIT_RX,
            ST_SETTLE: begin
                c.tx_dig_rst = 1'b0;
                c.rx_ana_rst = 1'b0;
            end
            ST_LTD: begin
                c.tx_dig_rst = 1'b0;
                c.rx_ana_rst = 1'b0;
                c.ref_sel    = 1'b0;
                c.data_sel   = 1'b1;
            end
            ST_RUN: begin
                c.tx_dig_rst = 1'b0;
                c.rx_ana_rst = 1'b0;
                c.rx_dig_rst = 1'b0;
                c.ref_sel    = 1'b0;
                c.data_sel   = 1'b1;
            end
            default:       c.pll_pwrdn = 1'b1;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/xrs_sync.sv
module xrs_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d_async;
            stage2 <= stage1;
        end
    end

    assign d_sync = stage2;
endmodule

// File: rtl/xrs_timer.sv
module xrs_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    // Saturating cycle counter, zero in the first cycle of each state.
    always_ff @(posedge clk) begin
        if (clr)
            cnt <= '0;
        else if (cnt != {W{1'b1}})
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/xcvr_rst_seq.sv
module xcvr_rst_seq
    import xrs_pkg::*;
#(
    parameter int CLK_MHZ   = 100,
    parameter int PWRDN_NS  = 1000,
    parameter int TXREL_CYC = 2,
    parameter int RXANA_NS  = 4000,
    parameter int SETTLE_NS = 15000,
    parameter int RXDIG_NS  = 4000
) (
    input  logic clk,
    input  logic rst,
    input  logic restart_req,
    input  logic tx_lock_a,
    input  logic rx_lock_a,
    input  logic rx_freq_lock_a,
    output logic pll_pwrdn,
    output logic tx_dig_rst,
    output logic rx_ana_rst,
    output logic rx_dig_rst,
    output logic cdr_ref_sel,
    output logic cdr_data_sel,
    output logic busy,
    output logic done
);
    localparam int PWRDN_CYC  = ns_to_cyc(PWRDN_NS, CLK_MHZ);
    localparam int TXREL_C    = (TXREL_CYC < 1) ? 1 : TXREL_CYC;
    localparam int RXANA_CYC  = ns_to_cyc(RXANA_NS, CLK_MHZ);
    localparam int SETTLE_CYC = ns_to_cyc(SETTLE_NS, CLK_MHZ);
    localparam int RXDIG_CYC  = ns_to_cyc(RXDIG_NS, CLK_MHZ);
    localparam int MAX_CYC    = max2(max2(PWRDN_CYC, TXREL_C),
                                     max2(max2(RXANA_CYC, SETTLE_CYC), RXDIG_CYC));
    localparam int CNT_W      = $clog2(MAX_CYC + 1) + 1;

    localparam logic [CNT_W-1:0] PWRDN_LIM  = CNT_W'(PWRDN_CYC - 1);
    localparam logic [CNT_W-1:0] TXREL_LIM  = CNT_W'(TXREL_C - 1);
    localparam logic [CNT_W-1:0] RXANA_LIM  = CNT_W'(RXANA_CYC - 1);
    localparam logic [CNT_W-1:0] SETTLE_LIM = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] RXDIG_LIM  = CNT_W'(RXDIG_CYC - 1);

    // Lock synchronizer: bit 0 transmit, bit 1 receive PLL, bit 2 frequency
    logic [2:0] lock_s;
    logic       tx_s, rx_s, freq_s;

    xrs_sync #(.W(3)) i_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async ({rx_freq_lock_a, rx_lock_a, tx_lock_a}),
        .d_sync  (lock_s)
    );

    assign tx_s   = lock_s[0];
    assign rx_s   = lock_s[1];
    assign freq_s = lock_s[2];

    seq_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt;
    logic             tmr_clr;
    logic             tx_lost;
    ctl_t             ctl;

    assign tmr_clr = rst || restart_req || (state_d != state_q);

    xrs_timer #(.W(CNT_W)) i_timer (
        .clk (clk),
        .clr (tmr_clr),
        .cnt (cnt)
    );

    assign tx_lost = !tx_s && (state_q != ST_PWRDN) && (state_q != ST_WAIT_TX);

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_PWRDN:      if (cnt >= PWRDN_LIM)  state_d = ST_WAIT_TX;
            ST_WAIT_TX:    if (tx_s)              state_d = ST_TX_HOLD;
            ST_TX_HOLD:    if (cnt >= TXREL_LIM)  state_d = ST_RXANA_HOLD;
            ST_RXANA_HOLD: if (cnt >= RXANA_LIM)  state_d = ST_WAIT_RX;
            ST_WAIT_RX:    if (rx_s)              state_d = ST_SETTLE;
            ST_SETTLE: begin
                if (!rx_s)                    state_d = ST_RXANA_HOLD;
                else if (cnt >= SETTLE_LIM)   state_d = ST_LTD;
            end
            ST_LTD: begin
                if (!rx_s)                          state_d = ST_RXANA_HOLD;
                else if (cnt >= RXDIG_LIM && freq_s) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!rx_s)        state_d = ST_RXANA_HOLD;
                else if (!freq_s) state_d = ST_LTD;
            end
            default:              state_d = ST_PWRDN;
        endcase
        if (tx_lost)     state_d = ST_PWRDN;
        if (restart_req) state_d = ST_PWRDN;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_PWRDN;
        else     state_q <= state_d;
    end

    assign ctl          = decode(state_q);
    assign pll_pwrdn    = ctl.pll_pwrdn;
    assign tx_dig_rst   = ctl.tx_dig_rst;
    assign rx_ana_rst   = ctl.rx_ana_rst;
    assign rx_dig_rst   = ctl.rx_dig_rst;
    assign cdr_ref_sel  = ctl.ref_sel;
    assign cdr_data_sel = ctl.data_sel;
    assign busy         = (state_q != ST_RUN);
    assign done         = (state_q == ST_RUN);

    // Run-length counters used only by the checks below
    logic [CNT_W-1:0] pwr_run;
    logic [CNT_W-1:0] ltd_run;

    always_ff @(posedge clk) begin
        if (rst || !pll_pwrdn)             pwr_run <= '0;
        else if (pwr_run != {CNT_W{1'b1}}) pwr_run <= pwr_run + 1'b1;
        if (rst || !(cdr_data_sel && rx_dig_rst)) ltd_run <= '0;
        else if (ltd_run != {CNT_W{1'b1}})        ltd_run <= ltd_run + 1'b1;
    end

    AST_PWRDN_HOLD: assert property (@(posedge clk) disable iff (rst)
        $fell(pll_pwrdn) |-> pwr_run >= CNT_W'(PWRDN_CYC)); // R2

    AST_REF_TO_DATA: assert property (@(posedge clk) disable iff (rst)
        $rose(cdr_data_sel) |-> $fell(cdr_ref_sel) && $past(rx_s)); // R5

    AST_RXDIG_HOLD: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_dig_rst) |-> ltd_run >= CNT_W'(RXDIG_CYC)); // R6

    AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy && !tx_dig_rst && !rx_ana_rst && !rx_dig_rst && cdr_data_sel); // R7

    AST_RXDIG_FREQ: assert property (@(posedge clk) disable iff (rst)
        $fell(rx_dig_rst) |-> $past(freq_s)); // R8

    AST_TX_LOSS: assert property (@(posedge clk) disable iff (rst)
        ($fell(tx_s) && !pll_pwrdn) |=> pll_pwrdn); // R10

    AST_RESTART: assert property (@(posedge clk) disable iff (rst)
        restart_req |=> pll_pwrdn); // R11
endmodule

// File: tb/test_xcvr_rst_seq.sv
`timescale 1ns/1ps
module test_xcvr_rst_seq;
    localparam int MHZ  = 4;
    localparam int N1   = 4;   // 1 us at 4 MHz
    localparam int NANA = 16;  // 4 us
    localparam int N15  = 60;  // 15 us
    localparam int NDIG = 16;  // 4 us
    localparam int T3   = 2;

    logic clk = 1'b0;
    logic rst, restart_req, tx_lock_a, rx_lock_a, rx_freq_lock_a;
    logic pll_pwrdn, tx_dig_rst, rx_ana_rst, rx_dig_rst;
    logic cdr_ref_sel, cdr_data_sel, busy, done;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    xcvr_rst_seq #(.CLK_MHZ(MHZ), .TXREL_CYC(T3)) i_xcvr_rst_seq (
        .clk(clk), .rst(rst), .restart_req(restart_req),
        .tx_lock_a(tx_lock_a), .rx_lock_a(rx_lock_a), .rx_freq_lock_a(rx_freq_lock_a),
        .pll_pwrdn(pll_pwrdn), .tx_dig_rst(tx_dig_rst), .rx_ana_rst(rx_ana_rst),
        .rx_dig_rst(rx_dig_rst), .cdr_ref_sel(cdr_ref_sel), .cdr_data_sel(cdr_data_sel),
        .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; restart_req = 1'b0;
        tx_lock_a = 1'b0; rx_lock_a = 1'b0; rx_freq_lock_a = 1'b0;
        step(3);
        rst = 1'b0;
    endtask

    task automatic bring_up_to_ltd(input bit freq);
        do_reset();
        tx_lock_a = 1'b1;
        for (int i = 0; i < 2000 && rx_ana_rst; i++) step(1);
        rx_lock_a = 1'b1;
        rx_freq_lock_a = freq;
        for (int i = 0; i < 2000 && !cdr_data_sel; i++) step(1);
    endtask

    task automatic wait_done();
        for (int i = 0; i < 2000 && !done; i++) step(1);
    endtask

    task automatic t_reset_state();
        rst = 1'b1; restart_req = 1'b0;
        tx_lock_a = 1'b1; rx_lock_a = 1'b1; rx_freq_lock_a = 1'b1;
        step(4);
        chk(pll_pwrdn && tx_dig_rst && rx_ana_rst && rx_dig_rst && cdr_ref_sel && busy,
            "R1 resets", {pll_pwrdn, tx_dig_rst, rx_ana_rst, rx_dig_rst, cdr_ref_sel, busy}, 63);
        chk(!cdr_data_sel && !done, "R1 data_sel/done", {cdr_data_sel, done}, 0);
    endtask

    task automatic t_full_sequence();
        int n;
        do_reset();
        n = 0;
        while (pll_pwrdn && n < 5000) begin n++; step(1); end
        chk(n == N1, "R2 pwrdn hold", n, N1);
        tx_lock_a = 1'b1;
        n = 0;
        while (tx_dig_rst && n < 5000) begin n++; step(1); end
        chk(n == 3 + T3, "R3 tx release", n, 3 + T3);
        n = 0;
        while (rx_ana_rst && n < 5000) begin n++; step(1); end
        chk(n == NANA, "R4 rx analog hold", n, NANA);
        chk(cdr_ref_sel && !cdr_data_sel, "R5 ref before lock", cdr_ref_sel, 1);
        rx_lock_a = 1'b1; rx_freq_lock_a = 1'b1;
        n = 0;
        while (cdr_ref_sel && n < 5000) begin n++; step(1); end
        chk(n == N15 + 3, "R5 settle", n, N15 + 3);
        chk(cdr_data_sel, "R5 data_sel same cycle", cdr_data_sel, 1);
        n = 0;
        while (rx_dig_rst && n < 5000) begin n++; step(1); end
        chk(n == NDIG, "R6 rx digital hold", n, NDIG);
        chk(done && !busy && !tx_dig_rst && !rx_ana_rst && !pll_pwrdn, "R7 run state",
            {done, busy, tx_dig_rst, rx_ana_rst, pll_pwrdn}, 16);
    endtask

    task automatic t_rx_loss();
        rx_lock_a = 1'b0;
        step(2);
        chk(done == 1'b1, "R12 rx sync latency", done, 1);
        step(1);
        chk(rx_ana_rst && rx_dig_rst && cdr_ref_sel && !cdr_data_sel && busy,
            "R9 rx loss resets", {rx_ana_rst, rx_dig_rst, cdr_ref_sel, cdr_data_sel, busy}, 29);
        chk(!tx_dig_rst && !pll_pwrdn, "R9 tx side kept", {tx_dig_rst, pll_pwrdn}, 0);
        rx_lock_a = 1'b1;
        wait_done();
        chk(done, "R9 recovery", done, 1);
    endtask

    task automatic t_tx_loss();
        tx_lock_a = 1'b0;
        step(2);
        chk(!pll_pwrdn, "R12 tx sync latency", pll_pwrdn, 0);
        step(1);
        chk(pll_pwrdn && tx_dig_rst && busy, "R10 tx loss", {pll_pwrdn, tx_dig_rst, busy}, 7);
        tx_lock_a = 1'b1;
    endtask

    task automatic t_freq_wait();
        int n;
        bring_up_to_ltd(1'b0);
        step(3 * NDIG);
        chk(rx_dig_rst && cdr_data_sel, "R8 held without freq", rx_dig_rst, 1);
        rx_freq_lock_a = 1'b1;
        n = 0;
        while (rx_dig_rst && n < 5000) begin n++; step(1); end
        chk(n == 3, "R8 release after freq", n, 3);
        chk(done, "R8 done", done, 1);
    endtask

    task automatic t_restart();
        int n;
        bring_up_to_ltd(1'b1);
        wait_done();
        chk(done, "R11 precondition", done, 1);
        restart_req = 1'b1;
        step(1);
        restart_req = 1'b0;
        chk(pll_pwrdn && busy && !done, "R11 restart", {pll_pwrdn, busy, done}, 6);
        n = 0;
        while (pll_pwrdn && n < 5000) begin n++; step(1); end
        chk(n == N1, "R2 pwrdn with locks high", n, N1);
        wait_done();
        chk(done, "R11 completes again", done, 1);
    endtask

    initial begin
        step(1);
        t_reset_state();
        t_full_sequence();
        t_rx_loss();
        t_tx_loss();
        t_freq_wait();
        t_restart();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(5 * 150000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule